// File: doc/BRIEF.md
# Incremental Position Output Formatter

This block turns a stream of single-step position events from an upstream interpolator into output pin patterns. Each event is a one-cycle step strobe with a direction bit, and an index flag marks the reference position. A 4-bit mode word selects what the six differential-style output pins and the fault pin carry.

In quadrature mode the block walks a two-bit Gray state and drives A, B and a zero marker, each paired with its inverse. In counter-control mode the same steps become strobes for external up/down counter chips. These are separate down and up count clocks, a shared count clock, a direction level, and an active-high reset and active-low load that follow the index. Each count clock is a low-going pulse whose width is a whole number of clock cycles. One step that arrives during a pulse is held back and issued afterwards. A further step is lost and raises the fault pin. Two forcing modes drive every pin low or high for board test. All other mode codes park the pins in a harmless idle pattern.

Top module: `incpos_fmt`

## Requirements
- R1: With mode 0x0, ch0_p carries A, ch1_p carries B and ch2_p carries the zero marker Z. Each of ch0_n, ch1_n and ch2_n is the inverse of its _p pin, and fault_o is 0.
- R2: In mode 0x0, a step with dir_i=0 moves the (B,A) state one place forward in the cycle 00, 01, 11, 10, 00. A step with dir_i=1 moves it one place back. The new state shows one cycle after the step is sampled, and only one of A or B changes per step.
- R3: With mode 0xF, ch0_p is the down-count clock and pulses only for dir_i=1 steps. ch0_n is the up-count clock and pulses only for dir_i=0 steps. ch1_p is the shared clock and pulses for every step. Each pulse is low for PULSE_CYC cycles, beginning SETUP_CYC cycles after the step is sampled, and all three clocks idle high.
- R4: With mode 0xF, ch1_n gives the direction (0 up, 1 down). It takes the new value on the cycle after the step is accepted and holds it through the pulse.
- R5: With mode 0xF, ch2_p is 1 and ch2_n is 0 on the cycle after index_i is sampled high. Otherwise ch2_p is 0 and ch2_n is 1. In mode 0x0, Z follows index_i with the same one-cycle lag.
- R6: With mode 0xF, one step sampled while a pulse is in progress is stored. It is issued when the pulse ends, with its own SETUP_CYC high gap before its low phase.
- R7: With mode 0xF, a step sampled while the stored step is still waiting is dropped, and fault_o goes to 1 on the next cycle. fault_o stays at 1 while the mode stays 0xF. Leaving mode 0xF clears the fault and cancels any pulse.
- R8: Mode 0x8 drives all six pins and fault_o to 0. Mode 0x9 drives all six pins and fault_o to 1.
- R9: Any other mode code gives ch0_p=ch0_n=ch1_p=1, ch1_n=0, ch2_p=0, ch2_n=1 and fault_o=0.
- R10: After reset the Gray state is 00, no pulse or stored step is pending, the fault flag is clear, the direction level is 0 and the zero marker is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Output mode select |
| step_i | input | 1 | One-cycle step event |
| dir_i | input | 1 | Step direction: 0 up, 1 down |
| index_i | input | 1 | High while the index position is reached |
| ch0_p | output | 1 | A, or down-count clock |
| ch0_n | output | 1 | Inverse A, or up-count clock |
| ch1_p | output | 1 | B, or shared count clock |
| ch1_n | output | 1 | Inverse B, or count direction |
| ch2_p | output | 1 | Z, or master reset (active high) |
| ch2_n | output | 1 | Inverse Z, or load/reset (active low) |
| fault_o | output | 1 | Overflow fault, or forced level |

## Verification
The bench builds the block with SETUP_CYC=2 and PULSE_CYC=4 rather than the 110 ns default. The two timing windows then differ, so the bench can tell an off-by-one in either counter apart from one in the other. A full pulse also finishes in a few cycles. That makes it cheap to run back-to-back steps, a stored step issued right after a pulse, and a third step that overflows the stored slot, all within one short run.

// File: rtl/incpos_pkg.sv
package incpos_pkg;

  localparam logic [3:0] MODE_QUAD    = 4'h0;
  localparam logic [3:0] MODE_FORCE_0 = 4'h8;
  localparam logic [3:0] MODE_FORCE_1 = 4'h9;
  localparam logic [3:0] MODE_COUNTER = 4'hF;

  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_SETUP = 2'd1,
    PG_LOW   = 2'd2
  } pg_state_t;

  typedef struct packed {
    logic c0p;
    logic c0n;
    logic c1p;
    logic c1n;
    logic c2p;
    logic c2n;
    logic flt;
  } pins_t;

  // position index of the quadrature cycle, moved one place per step
  function automatic logic [1:0] quad_step(input logic [1:0] pos, input logic down);
    return down ? pos - 2'd1 : pos + 2'd1;
  endfunction

  // Gray pattern {B,A} for a position index: 0->00, 1->01, 2->11, 3->10
  function automatic logic [1:0] quad_gray(input logic [1:0] pos);
    return pos ^ (pos >> 1);
  endfunction

endpackage

// File: rtl/incpos_quad.sv
module incpos_quad
  import incpos_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic dir,
  input  logic index,
  output logic qa,
  output logic qb,
  output logic qz
);

  logic [1:0] pos_q;
  logic       z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 2'd0;
      z_q   <= 1'b0;
    end else begin
      z_q <= index;
      if (step) pos_q <= quad_step(pos_q, dir);
    end
  end

  logic [1:0] gray;
  assign gray = quad_gray(pos_q);
  assign qa   = gray[0];
  assign qb   = gray[1];
  assign qz   = z_q;

endmodule

// File: rtl/incpos_pulse.sv
module incpos_pulse
  import incpos_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic step,
  input  logic dir,
  output logic cpd_n,
  output logic cpu_n,
  output logic cp_n,
  output logic dir_o,
  output logic ovf,
  output logic ovf_evt,
  output logic low_phase
);

  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);

  pg_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q;
  logic          pend_v_q;
  logic          pend_dir_q;
  logic          ovf_q;

  logic busy, last_low, take, stash;

  assign busy     = (state_q != PG_IDLE);
  assign last_low = (state_q == PG_LOW) && (cnt_q == '0);
  assign take     = last_low && pend_v_q;
  assign stash    = en && step && busy && (!pend_v_q || take);
  assign ovf_evt  = en && step && busy && pend_v_q && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PG_IDLE;
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_dir_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else if (!en) begin
      state_q    <= PG_IDLE;
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_dir_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      case (state_q)
        PG_IDLE: begin
          if (step) begin
            state_q <= PG_SETUP;
            cnt_q   <= SETUP_LD;
            dir_q   <= dir;
          end
        end
        PG_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= PG_LOW;
            cnt_q   <= PULSE_LD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PG_LOW: begin
          if (cnt_q == '0) begin
            if (pend_v_q) begin
              state_q <= PG_SETUP;
              cnt_q   <= SETUP_LD;
              dir_q   <= pend_dir_q;
            end else begin
              state_q <= PG_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= PG_IDLE;
      endcase

      if (stash) begin
        pend_v_q   <= 1'b1;
        pend_dir_q <= dir;
      end else if (take) begin
        pend_v_q <= 1'b0;
      end

      if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  assign low_phase = (state_q == PG_LOW);
  assign cp_n      = !low_phase;
  assign cpd_n     = !(low_phase && dir_q);
  assign cpu_n     = !(low_phase && !dir_q);
  assign dir_o     = dir_q;
  assign ovf       = ovf_q;

endmodule

// File: rtl/incpos_mux.sv
module incpos_mux
  import incpos_pkg::*;
(
  input  logic [3:0] mode,
  input  logic       qa,
  input  logic       qb,
  input  logic       qz,
  input  logic       cpd_n,
  input  logic       cpu_n,
  input  logic       cp_n,
  input  logic       cdir,
  input  logic       ovf,
  output pins_t      pins
);

  always_comb begin
    // safe idle: clocks high, reset and load inactive
    pins = '{c0p: 1'b1, c0n: 1'b1, c1p: 1'b1, c1n: 1'b0,
             c2p: 1'b0, c2n: 1'b1, flt: 1'b0};
    case (mode)
      MODE_QUAD: begin
        pins = '{c0p: qa, c0n: !qa, c1p: qb, c1n: !qb,
                 c2p: qz, c2n: !qz, flt: 1'b0};
      end
      MODE_COUNTER: begin
        pins = '{c0p: cpd_n, c0n: cpu_n, c1p: cp_n, c1n: cdir,
                 c2p: qz, c2n: !qz, flt: ovf};
      end
      MODE_FORCE_0: pins = '0;
      MODE_FORCE_1: pins = '1;
      default: ;
    endcase
  end

endmodule

// File: rtl/incpos_fmt.sv
module incpos_fmt
  import incpos_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       step_i,
  input  logic       dir_i,
  input  logic       index_i,
  output logic       ch0_p,
  output logic       ch0_n,
  output logic       ch1_p,
  output logic       ch1_n,
  output logic       ch2_p,
  output logic       ch2_n,
  output logic       fault_o
);

  logic  qa, qb, qz;
  logic  cpd_n, cpu_n, cp_n, cdir, ovf;
  logic  ovf_evt, low_phase, cnt_en;
  pins_t pins;

  assign cnt_en = (mode_i == MODE_COUNTER);

  incpos_quad u_quad (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_i),
    .dir   (dir_i),
    .index (index_i),
    .qa    (qa),
    .qb    (qb),
    .qz    (qz)
  );

  incpos_pulse #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cnt_en),
    .step      (step_i),
    .dir       (dir_i),
    .cpd_n     (cpd_n),
    .cpu_n     (cpu_n),
    .cp_n      (cp_n),
    .dir_o     (cdir),
    .ovf       (ovf),
    .ovf_evt   (ovf_evt),
    .low_phase (low_phase)
  );

  incpos_mux u_mux (
    .mode  (mode_i),
    .qa    (qa),
    .qb    (qb),
    .qz    (qz),
    .cpd_n (cpd_n),
    .cpu_n (cpu_n),
    .cp_n  (cp_n),
    .cdir  (cdir),
    .ovf   (ovf),
    .pins  (pins)
  );

  assign ch0_p   = pins.c0p;
  assign ch0_n   = pins.c0n;
  assign ch1_p   = pins.c1p;
  assign ch1_n   = pins.c1n;
  assign ch2_p   = pins.c2p;
  assign ch2_n   = pins.c2n;
  assign fault_o = pins.flt;

endmodule

// File: rtl/incpos_fmt_chk.sv
module incpos_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_i,
  input logic       ch0_p,
  input logic       ch0_n,
  input logic       ch1_p,
  input logic       ch1_n,
  input logic       ch2_p,
  input logic       ch2_n,
  input logic       fault_o,
  input logic       ovf_evt,
  input logic       low_phase
);

  assert_quad_pairs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'h0) |-> (ch0_n == !ch0_p && ch1_n == !ch1_p && ch2_n == !ch2_p && !fault_o));

  assert_gray_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'h0 && $past(mode_i) == 4'h0) |->
      ($countones({ch0_p, ch1_p} ^ {$past(ch0_p), $past(ch1_p)}) <= 1));

  assert_one_count_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'hF && !ch1_p) |-> (ch0_p != ch0_n));

  assert_clk_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'hF) |-> (ch1_p == !low_phase));

  assert_dir_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'hF && $past(mode_i) == 4'hF && $fell(ch1_p)) |-> $stable(ch1_n));

  assert_index_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'hF) |-> (ch2_p != ch2_n));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && mode_i == 4'hF) |=> (fault_o || mode_i != 4'hF));

  assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'h8) |-> ({ch0_p, ch0_n, ch1_p, ch1_n, ch2_p, ch2_n, fault_o} == 7'h00));

  assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'h9) |-> ({ch0_p, ch0_n, ch1_p, ch1_n, ch2_p, ch2_n, fault_o} == 7'h7F));

  assert_safe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 4'h0 && mode_i != 4'h8 && mode_i != 4'h9 && mode_i != 4'hF) |->
      ({ch0_p, ch0_n, ch1_p, ch1_n, ch2_p, ch2_n, fault_o} == 7'b1110010));

endmodule

bind incpos_fmt incpos_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .ch0_p     (ch0_p),
  .ch0_n     (ch0_n),
  .ch1_p     (ch1_p),
  .ch1_n     (ch1_n),
  .ch2_p     (ch2_p),
  .ch2_n     (ch2_n),
  .fault_o   (fault_o),
  .ovf_evt   (ovf_evt),
  .low_phase (low_phase)
);

// File: tb/incpos_fmt_bench.sv
module incpos_fmt_bench;

  localparam int S = 2;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_i = 4'h0;
  logic       step_i = 1'b0;
  logic       dir_i = 1'b0;
  logic       index_i = 1'b0;
  logic       ch0_p, ch0_n, ch1_p, ch1_n, ch2_p, ch2_n, fault_o;

  int nchk  = 0;
  int nfail = 0;

  always #5 clk = !clk;

  incpos_fmt #(.SETUP_CYC(S), .PULSE_CYC(P)) u_incpos_fmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .step_i  (step_i),
    .dir_i   (dir_i),
    .index_i (index_i),
    .ch0_p   (ch0_p),
    .ch0_n   (ch0_n),
    .ch1_p   (ch1_p),
    .ch1_n   (ch1_n),
    .ch2_p   (ch2_p),
    .ch2_n   (ch2_n),
    .fault_o (fault_o)
  );

  logic [6:0] pins;
  assign pins = {ch0_p, ch0_n, ch1_p, ch1_n, ch2_p, ch2_n, fault_o};

  // {step, dir, index, expected A, expected B, expected Z}
  localparam logic [5:0] QVEC [9] = '{
    6'b100_100, 6'b100_110, 6'b101_011, 6'b100_000, 6'b110_010,
    6'b001_011, 6'b110_110, 6'b110_100, 6'b110_000
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [6:0] cnt_pins(input logic lo_d, input logic lo_u,
                                          input logic d, input logic idx, input logic f);
    return {!lo_d, !lo_u, !(lo_d || lo_u), d, idx, !idx, f};
  endfunction

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state, quadrature view
    chk("R10 in reset", pins, 7'b0101010);
    rst_n = 1'b1;
    tick();
    chk("R10 after reset", pins, 7'b0101010);

    // R1 R2 R5: quadrature vector walk
    for (int i = 0; i < 9; i++) begin
      step_i  = QVEC[i][5];
      dir_i   = QVEC[i][4];
      index_i = QVEC[i][3];
      tick();
      chk($sformatf("R1/R2 vec %0d", i), pins,
          {QVEC[i][2], !QVEC[i][2], QVEC[i][1], !QVEC[i][1], QVEC[i][0], !QVEC[i][0], 1'b0});
    end
    step_i = 1'b0; index_i = 1'b0;
    tick();

    // R8 forced levels, R9 safe idle
    mode_i = 4'h8; tick(); chk("R8 force low", pins, 7'h00);
    mode_i = 4'h9; tick(); chk("R8 force high", pins, 7'h7F);
    mode_i = 4'h5; tick(); chk("R9 idle code 5", pins, 7'b1110010);
    mode_i = 4'hE; tick(); chk("R9 idle code E", pins, 7'b1110010);

    // counter mode idle, then R5 index strobes
    mode_i = 4'hF; tick();
    chk("R3 counter idle", pins, 7'b1110010);
    index_i = 1'b1; tick();
    chk("R5 index reached", pins, 7'b1110100);
    index_i = 1'b0; tick();
    chk("R5 index left", pins, 7'b1110010);

    // R3 R4 up step then down step
    for (int d = 0; d < 2; d++) begin
      step_i = 1'b1; dir_i = d[0];
      for (int k = 0; k <= S + P; k++) begin
        tick();
        step_i = 1'b0;
        begin
          logic lo;
          lo = (k >= S) && (k <= S + P - 1);
          chk($sformatf("R3/R4 dir %0d cycle %0d", d, k), pins,
              cnt_pins(lo && d[0], lo && !d[0], d[0], 1'b0, 1'b0));
        end
      end
    end

    // R6: up step, then down step during the pulse
    step_i = 1'b1; dir_i = 1'b0;
    for (int k = 0; k <= 2*(S + P); k++) begin
      tick();
      step_i = (k == 0);
      dir_i  = 1'b1;
      begin
        logic lo1, lo2, dd;
        lo1 = (k >= S) && (k <= S + P - 1);
        lo2 = (k >= 2*S + P) && (k <= 2*S + 2*P - 1);
        dd  = (k >= S + P);
        chk($sformatf("R6 stored step cycle %0d", k), pins,
            cnt_pins(lo2, lo1, dd, 1'b0, 1'b0));
      end
    end
    step_i = 1'b0;

    // R7: three steps back to back, third overflows
    step_i = 1'b1; dir_i = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick();
      step_i = (k < 2);
      if (k <= 2) chk($sformatf("R7 fault cycle %0d", k), {6'b0, fault_o}, {6'b0, k == 2});
    end
    chk("R7 fault sticky", {6'b0, fault_o}, 7'd1);
    mode_i = 4'h0; tick();
    chk("R7 fault hidden in quad mode", {6'b0, fault_o}, 7'd0);
    mode_i = 4'hF; tick();
    chk("R7 fault cleared on mode exit", pins, 7'b1110010);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule